// File: doc/BRIEF.md
# Processor trap entry controller

This block performs the state changes a small 32-bit in-order core with one branch delay slot makes when it enters a trap. The core presents the current program counter, the pending branch target, its machine status word, the flags of the instruction being executed, and the kind of trap: a hardware exception (unaligned access), a memory-management fault, an external interrupt or a break. It also presents the fault details. While the one-cycle `take` strobe is high, the block decides whether the trap is accepted. On the next clock edge it commits the new program counter, the link register write, the updated status word, the exception status word, the exception address and the branch target copy. In the same cycle it pulses the requests that clear the load reservation and the per-instruction flags.

Each trap class has a fixed vector offset from a configurable base and a fixed link register. For memory-management faults the saved return address rewinds by 0, 4 or 8 bytes, so that an interrupted branch or immediate prefix runs again. Every entry stacks the translation-enable and user-mode bits into their saved copies. An external interrupt is refused unless the core is in a state where it can take one. A second memory-management fault that arrives while the handler for the first one is still running does not re-enter. It sets a sticky double-fault flag instead.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A synchronous reset sets `pc_q` to `VEC_BASE`. It clears `msr_q`, `esr_q`, `ear_q`, `btr_q`, `dfault` and all pulse outputs.
- R2: An accepted trap loads `pc_q` with `VEC_BASE` plus 0x10 for an interrupt (kind 2), plus 0x18 for a break (kind 3), and plus 0x20 for a hardware exception (kind 0) or a memory-management fault (kind 1).
- R3: An accepted trap writes the link register for one cycle. An interrupt writes `cur_pc` to register 14 and a break writes `cur_pc` to register 16. A hardware exception writes `cur_pc + 4` to register 17.
- R4: A memory-management fault writes register 17 with `cur_pc - 8` when `in_dly` and `br_imm` are both set. It writes `cur_pc - 4` when only `in_dly` is set or when `after_imm` is set. In all other cases it writes `cur_pc`.
- R5: On an accepted exception (kind 0 or 1), ESR bit 12 takes the value of `in_dly`, and `btr_q` loads `br_target` only when `in_dly` is set. Otherwise `btr_q` keeps its value.
- R6: A memory-management fault loads ESR bits 4:0 with 16 + 2·`miss` + (access is fetch), and sets bit 10 for a store. The access codes are 0 for load, 1 for store and 2 for fetch. The fault loads `ear_q` with `fault_addr`.
- R7: A hardware exception loads ESR bits 4:0 with cause 1. It places `syn` in bits 11:5 only when `syn_valid` is set, and it loads `ear_q` with `fault_addr`.
- R8: An accepted trap copies status bit 11 (user mode) to bit 12 and bit 13 (translation) to bit 14, and then clears bits 11 and 13. An interrupt also clears bit 1 (interrupt enable), a break sets bit 3 (break in progress) and an exception sets bit 9 (exception in progress). All other bits pass through unchanged.
- R9: `irq_ok` is high only when status bit 1 is set, bits 9 and 3 are clear, and neither `in_dly` nor `after_imm` is set. A refused interrupt changes no output state.
- R10: With `EXC_EN` = 0, a hardware exception request is ignored and produces no entry.
- R11: Each accepted trap raises `entered`, `resv_clr` and `iflag_clr` for exactly one cycle. Interrupts and breaks leave `esr_q` and `ear_q` unchanged.
- R12: A memory-management fault raises `dfault` instead of entering when an earlier one is still pending, meaning status bit 9 is set and the status word has not shown bit 9 clear while idle. `dfault` then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take | input | 1 | One-cycle trap request strobe |
| kind | input | 2 | Trap kind: 0 exception, 1 MMU fault, 2 interrupt, 3 break |
| cur_pc | input | XLEN | Address of the current instruction |
| br_target | input | XLEN | Pending branch target |
| cur_msr | input | XLEN | Current machine status word |
| in_dly | input | 1 | Instruction sits in a delay slot |
| after_imm | input | 1 | Instruction follows an immediate prefix |
| br_imm | input | 1 | Delay slot belongs to a branch with immediate prefix |
| acc | input | 2 | Faulting access: 0 load, 1 store, 2 fetch |
| miss | input | 1 | MMU fault was a miss (1) or protection error (0) |
| syn_valid | input | 1 | Syndrome bits are valid |
| syn | input | 7 | Instruction syndrome bits |
| fault_addr | input | XLEN | Faulting data address |
| irq_ok | output | 1 | Interrupt would be accepted now |
| pc_q | output | XLEN | New program counter |
| msr_q | output | XLEN | Updated status word |
| esr_q | output | ESR_W | Exception status word |
| ear_q | output | XLEN | Exception address |
| btr_q | output | XLEN | Branch target copy |
| lnk_we | output | 1 | Link register write strobe |
| lnk_sel | output | 5 | Link register index |
| lnk_val | output | XLEN | Link register value |
| resv_clr | output | 1 | Clear the load reservation |
| iflag_clr | output | 1 | Clear the per-instruction flags |
| entered | output | 1 | A trap was entered on the last edge |
| dfault | output | 1 | Sticky double-fault flag |

## Verification
On every cycle, the assertions check the following properties. Each entry lands on one of the three vector addresses. The link index is one of 14, 16 or 17. The live mode bits are cleared and the user-mode bit is stacked from the previous status word. A refused interrupt never produces an entry, and the double-fault flag never drops. Only the bench's sweeps can show the exact rewind amounts, the ESR cause codes and the syndrome masking. They also show that refused and disabled traps leave every register unchanged, and that the double-fault condition arises only from the pending-fault sequence.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [1:0] {
      TK_EXC = 2'd0,
      TK_MMU = 2'd1,
      TK_IRQ = 2'd2,
      TK_BRK = 2'd3
   } trap_kind_e;

   typedef enum logic [1:0] {
      AC_LOAD  = 2'd0,
      AC_STORE = 2'd1,
      AC_FETCH = 2'd2
   } access_e;

   // status word bit positions; saved copies sit one above the live ones
   localparam int MB_IE  = 1;
   localparam int MB_BIP = 3;
   localparam int MB_EIP = 9;
   localparam int MB_UM  = 11;
   localparam int MB_UMS = 12;
   localparam int MB_VM  = 13;
   localparam int MB_VMS = 14;

   // exception status word layout
   localparam int EB_DLY    = 12;
   localparam int EB_STORE  = 10;
   localparam int SYN_LO    = 5;
   localparam int SYN_W     = 7;
   localparam int CAUSE_W   = 5;
   localparam logic [CAUSE_W-1:0] CAUSE_UNALIGNED = 5'd1;
   localparam logic [2:0] CAUSE_MMU_HI = 3'b100;

   localparam int LNK_W   = 5;
   localparam logic [LNK_W-1:0] LNK_IRQ = 5'd14;
   localparam logic [LNK_W-1:0] LNK_BRK = 5'd16;
   localparam logic [LNK_W-1:0] LNK_EXC = 5'd17;

   localparam logic [7:0] OFS_IRQ = 8'h10;
   localparam logic [7:0] OFS_BRK = 8'h18;
   localparam logic [7:0] OFS_EXC = 8'h20;
endpackage

// File: rtl/trap_ret_calc.sv
module trap_ret_calc import trap_pkg::*; #(
   parameter int XLEN = 32
) (
   input  logic [1:0]             kind,
   input  logic [XLEN-1:0]        pc,
   input  logic                   in_dly,
   input  logic                   after_imm,
   input  logic                   br_imm,
   output logic [LNK_W-1:0]       sel,
   output logic [XLEN-1:0]        val,
   output logic [XLEN-1:0]        vec_ofs
);
   logic [XLEN-1:0] rewind;

   always_comb begin
      if (in_dly)         rewind = br_imm ? XLEN'(8) : XLEN'(4);
      else if (after_imm) rewind = XLEN'(4);
      else                rewind = '0;
   end

   always_comb begin
      case (trap_kind_e'(kind))
         TK_IRQ: begin
            sel = LNK_IRQ;  val = pc;            vec_ofs = XLEN'(OFS_IRQ);
         end
         TK_BRK: begin
            sel = LNK_BRK;  val = pc;            vec_ofs = XLEN'(OFS_BRK);
         end
         TK_MMU: begin
            sel = LNK_EXC;  val = pc - rewind;   vec_ofs = XLEN'(OFS_EXC);
         end
         default: begin
            sel = LNK_EXC;  val = pc + XLEN'(4); vec_ofs = XLEN'(OFS_EXC);
         end
      endcase
   end
endmodule

// File: rtl/trap_cause.sv
module trap_cause import trap_pkg::*; #(
   parameter int ESR_W = 16
) (
   input  logic [1:0]       kind,
   input  logic             in_dly,
   input  logic [1:0]       acc,
   input  logic             miss,
   input  logic             syn_valid,
   input  logic [SYN_W-1:0] syn,
   input  logic [ESR_W-1:0] esr_old,
   output logic [ESR_W-1:0] esr_new
);
   always_comb begin
      esr_new = esr_old;
      case (trap_kind_e'(kind))
         TK_EXC: begin
            esr_new = '0;
            esr_new[CAUSE_W-1:0] = CAUSE_UNALIGNED;
            if (syn_valid) esr_new[SYN_LO +: SYN_W] = syn;
            esr_new[EB_DLY] = in_dly;
         end
         TK_MMU: begin
            esr_new = '0;
            esr_new[CAUSE_W-1:0] = {CAUSE_MMU_HI, miss, access_e'(acc) == AC_FETCH};
            esr_new[EB_STORE] = (access_e'(acc) == AC_STORE);
            esr_new[EB_DLY] = in_dly;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/trap_msr_stack.sv
module trap_msr_stack import trap_pkg::*; #(
   parameter int XLEN = 32
) (
   input  logic [1:0]      kind,
   input  logic [XLEN-1:0] msr_in,
   output logic [XLEN-1:0] msr_out
);
   always_comb begin
      msr_out = msr_in;
      case (trap_kind_e'(kind))
         TK_IRQ:  msr_out[MB_IE]  = 1'b0;
         TK_BRK:  msr_out[MB_BIP] = 1'b1;
         default: msr_out[MB_EIP] = 1'b1;
      endcase
      msr_out[MB_UMS] = msr_in[MB_UM];
      msr_out[MB_VMS] = msr_in[MB_VM];
      msr_out[MB_UM]  = 1'b0;
      msr_out[MB_VM]  = 1'b0;
   end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl import trap_pkg::*; #(
   parameter int              XLEN     = 32,
   parameter int              ESR_W    = 16,
   parameter logic [XLEN-1:0] VEC_BASE = '0,
   parameter bit              EXC_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  logic [1:0]        kind,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [XLEN-1:0]   br_target,
   input  logic [XLEN-1:0]   cur_msr,
   input  logic              in_dly,
   input  logic              after_imm,
   input  logic              br_imm,
   input  logic [1:0]        acc,
   input  logic              miss,
   input  logic              syn_valid,
   input  logic [6:0]        syn,
   input  logic [XLEN-1:0]   fault_addr,
   output logic              irq_ok,
   output logic [XLEN-1:0]   pc_q,
   output logic [XLEN-1:0]   msr_q,
   output logic [ESR_W-1:0]  esr_q,
   output logic [XLEN-1:0]   ear_q,
   output logic [XLEN-1:0]   btr_q,
   output logic              lnk_we,
   output logic [4:0]        lnk_sel,
   output logic [XLEN-1:0]   lnk_val,
   output logic              resv_clr,
   output logic              iflag_clr,
   output logic              entered,
   output logic              dfault
);
   localparam int MIN_XLEN  = MB_VMS + 1;
   localparam int MIN_ESR   = EB_DLY + 1;
   localparam int VEC_ALIGN = 6;

   if (XLEN < MIN_XLEN) begin : g_bad_xlen
      $error("XLEN too small for the status word layout");
   end
   if (ESR_W < MIN_ESR) begin : g_bad_esr
      $error("ESR_W too small for the exception status layout");
   end
   if (VEC_BASE[VEC_ALIGN-1:0] != '0) begin : g_bad_base
      $error("VEC_BASE must be 64-byte aligned");
   end

   logic               exc_allow;
   logic               mmu_pend_q;
   logic               is_exc, is_mmu, is_irq;
   logic               dbl, accept;
   logic [LNK_W-1:0]   sel_n;
   logic [XLEN-1:0]    link_n, vofs_n, msr_n;
   logic [ESR_W-1:0]   esr_n;

   if (EXC_EN) begin : g_exc_on
      assign exc_allow = 1'b1;
   end else begin : g_exc_off
      assign exc_allow = 1'b0;
   end

   assign is_exc = (trap_kind_e'(kind) == TK_EXC);
   assign is_mmu = (trap_kind_e'(kind) == TK_MMU);
   assign is_irq = (trap_kind_e'(kind) == TK_IRQ);

   assign irq_ok = cur_msr[MB_IE] & ~cur_msr[MB_EIP] & ~cur_msr[MB_BIP]
                   & ~in_dly & ~after_imm;

   assign dbl    = take & is_mmu & mmu_pend_q & cur_msr[MB_EIP];
   assign accept = take & ~dbl &
                   (is_irq ? irq_ok : (is_exc ? exc_allow : 1'b1));

   trap_ret_calc #(.XLEN(XLEN)) u_ret (
      .kind(kind), .pc(cur_pc), .in_dly(in_dly), .after_imm(after_imm),
      .br_imm(br_imm), .sel(sel_n), .val(link_n), .vec_ofs(vofs_n)
   );

   trap_cause #(.ESR_W(ESR_W)) u_cause (
      .kind(kind), .in_dly(in_dly), .acc(acc), .miss(miss),
      .syn_valid(syn_valid), .syn(syn), .esr_old(esr_q), .esr_new(esr_n)
   );

   trap_msr_stack #(.XLEN(XLEN)) u_msr (
      .kind(kind), .msr_in(cur_msr), .msr_out(msr_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q       <= VEC_BASE;
         msr_q      <= '0;
         esr_q      <= '0;
         ear_q      <= '0;
         btr_q      <= '0;
         lnk_we     <= 1'b0;
         lnk_sel    <= '0;
         lnk_val    <= '0;
         resv_clr   <= 1'b0;
         iflag_clr  <= 1'b0;
         entered    <= 1'b0;
         dfault     <= 1'b0;
         mmu_pend_q <= 1'b0;
      end else begin
         entered   <= accept;
         lnk_we    <= accept;
         resv_clr  <= accept;
         iflag_clr <= accept;
         dfault    <= dfault | dbl;
         if (accept) begin
            pc_q    <= VEC_BASE + vofs_n;
            msr_q   <= msr_n;
            lnk_sel <= sel_n;
            lnk_val <= link_n;
            if (is_exc || is_mmu) begin
               esr_q <= esr_n;
               ear_q <= fault_addr;
               if (in_dly) btr_q <= br_target;
            end
         end
         if (accept && is_mmu)
            mmu_pend_q <= 1'b1;
         else if (!take && !cur_msr[MB_EIP])
            mmu_pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk import trap_pkg::*; #(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] VEC_BASE = '0
) (
   input logic            clk,
   input logic            rst,
   input logic            take,
   input logic [1:0]      kind,
   input logic            cur_um,
   input logic            irq_ok,
   input logic [XLEN-1:0] pc_q,
   input logic            q_um,
   input logic            q_vm,
   input logic            q_ums,
   input logic            lnk_we,
   input logic [4:0]      lnk_sel,
   input logic            entered,
   input logic            dfault
);
   a_r2_vector: assert property (@(posedge clk) disable iff (rst)
      entered |-> (pc_q == VEC_BASE + XLEN'(OFS_IRQ) ||
                   pc_q == VEC_BASE + XLEN'(OFS_BRK) ||
                   pc_q == VEC_BASE + XLEN'(OFS_EXC)));

   a_r3_link_index: assert property (@(posedge clk) disable iff (rst)
      lnk_we |-> (lnk_sel == LNK_IRQ || lnk_sel == LNK_BRK || lnk_sel == LNK_EXC));

   a_r8_live_clear: assert property (@(posedge clk) disable iff (rst)
      entered |-> (!q_um && !q_vm));

   a_r8_user_saved: assert property (@(posedge clk) disable iff (rst)
      entered |-> (q_ums == $past(cur_um)));

   a_r9_refused_irq: assert property (@(posedge clk) disable iff (rst)
      (take && kind == 2'd2 && !irq_ok) |=> !entered);

   a_r11_needs_take: assert property (@(posedge clk) disable iff (rst)
      entered |-> $past(take));

   a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
      dfault |=> dfault);
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_chk (
   .clk(clk), .rst(rst), .take(take), .kind(kind),
   .cur_um(cur_msr[trap_pkg::MB_UM]), .irq_ok(irq_ok), .pc_q(pc_q),
   .q_um(msr_q[trap_pkg::MB_UM]), .q_vm(msr_q[trap_pkg::MB_VM]),
   .q_ums(msr_q[trap_pkg::MB_UMS]), .lnk_we(lnk_we), .lnk_sel(lnk_sel),
   .entered(entered), .dfault(dfault)
);

// File: tb/test_trap_entry_ctrl.sv
`timescale 1ns/1ps
module test_trap_entry_ctrl;
   localparam logic [31:0] BASE = 32'h0000_0100;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic take = 1'b0;
   logic [1:0] kind = '0;
   logic [31:0] cur_pc = '0, br_target = '0, cur_msr = '0, fault_addr = '0;
   logic in_dly = 0, after_imm = 0, br_imm = 0, miss = 0, syn_valid = 0;
   logic [1:0] acc = '0;
   logic [6:0] syn = '0;

   logic irq_ok, lnk_we, resv_clr, iflag_clr, entered, dfault;
   logic [31:0] pc_q, msr_q, ear_q, btr_q, lnk_val;
   logic [15:0] esr_q;
   logic [4:0] lnk_sel;

   logic n_irq_ok, n_lnk_we, n_resv, n_iflag, n_entered, n_dfault;
   logic [31:0] n_pc, n_msr, n_ear, n_btr, n_lval;
   logic [15:0] n_esr;
   logic [4:0] n_lsel;

   int total = 0, bad = 0;
   bit done = 0;

   logic [31:0] e_pc, e_msr, e_ear, e_btr;
   logic [15:0] e_esr;

   always #5 clk = ~clk;

   trap_entry_ctrl #(.VEC_BASE(BASE)) i_trap_entry_ctrl (
      .clk(clk), .rst(rst), .take(take), .kind(kind), .cur_pc(cur_pc),
      .br_target(br_target), .cur_msr(cur_msr), .in_dly(in_dly),
      .after_imm(after_imm), .br_imm(br_imm), .acc(acc), .miss(miss),
      .syn_valid(syn_valid), .syn(syn), .fault_addr(fault_addr),
      .irq_ok(irq_ok), .pc_q(pc_q), .msr_q(msr_q), .esr_q(esr_q),
      .ear_q(ear_q), .btr_q(btr_q), .lnk_we(lnk_we), .lnk_sel(lnk_sel),
      .lnk_val(lnk_val), .resv_clr(resv_clr), .iflag_clr(iflag_clr),
      .entered(entered), .dfault(dfault));

   trap_entry_ctrl #(.VEC_BASE(BASE), .EXC_EN(1'b0)) i_trap_entry_ctrl_noexc (
      .clk(clk), .rst(rst), .take(take), .kind(kind), .cur_pc(cur_pc),
      .br_target(br_target), .cur_msr(cur_msr), .in_dly(in_dly),
      .after_imm(after_imm), .br_imm(br_imm), .acc(acc), .miss(miss),
      .syn_valid(syn_valid), .syn(syn), .fault_addr(fault_addr),
      .irq_ok(n_irq_ok), .pc_q(n_pc), .msr_q(n_msr), .esr_q(n_esr),
      .ear_q(n_ear), .btr_q(n_btr), .lnk_we(n_lnk_we), .lnk_sel(n_lsel),
      .lnk_val(n_lval), .resv_clr(n_resv), .iflag_clr(n_iflag),
      .entered(n_entered), .dfault(n_dfault));

   task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", what, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic check_reset_state();
      chk("R1 pc", pc_q, BASE);
      chk("R1 msr", msr_q, 32'h0);
      chk("R1 esr", {16'h0, esr_q}, 32'h0);
      chk("R1 ear", ear_q, 32'h0);
      chk("R1 btr", btr_q, 32'h0);
      chk("R1 dfault", {31'h0, dfault}, 32'h0);
      chk("R1 pulses", {28'h0, entered, lnk_we, resv_clr, iflag_clr}, 32'h0);
      e_pc = BASE; e_msr = '0; e_esr = '0; e_ear = '0; e_btr = '0;
   endtask

   // one trap request followed by an idle cycle with a cleared status word
   task automatic run_trap(input logic [1:0] k, input logic [31:0] m,
                           input logic d, input logic im, input logic bi,
                           input logic [1:0] a, input logic ms,
                           input logic sv, input logic [6:0] sy,
                           input logic [31:0] pcv);
      logic ok_irq, acc_main, acc_n;
      logic [31:0] exp_link, mm;
      logic [4:0] exp_sel;
      @(negedge clk);
      take = 1; kind = k; cur_msr = m; in_dly = d; after_imm = im; br_imm = bi;
      acc = a; miss = ms; syn_valid = sv; syn = sy; cur_pc = pcv;
      br_target = pcv ^ 32'h5A5A_0000; fault_addr = pcv ^ 32'h00AB_C003;
      ok_irq = m[1] && !m[9] && !m[3] && !d && !im;
      #1;
      if (k == 2'd2) chk("R9 irq_ok", {31'h0, irq_ok}, {31'h0, ok_irq});
      acc_main = (k == 2'd2) ? ok_irq : 1'b1;
      acc_n    = (k == 2'd2) ? ok_irq : (k != 2'd0);
      @(posedge clk);
      @(negedge clk);
      take = 0; cur_msr = '0; in_dly = 0; after_imm = 0; br_imm = 0;
      if (acc_main) begin
         e_pc = BASE + ((k == 2'd2) ? 32'h10 : (k == 2'd3) ? 32'h18 : 32'h20);
         mm = m;
         if (k == 2'd2) mm[1] = 1'b0;
         else if (k == 2'd3) mm[3] = 1'b1;
         else mm[9] = 1'b1;
         mm[12] = m[11]; mm[14] = m[13]; mm[11] = 1'b0; mm[13] = 1'b0;
         e_msr = mm;
         if (k == 2'd0) begin
            exp_sel = 5'd17; exp_link = pcv + 32'd4;
            e_esr = 16'd1 | (sv ? {4'h0, sy, 5'h0} : 16'h0) | {3'h0, d, 12'h0};
         end else if (k == 2'd1) begin
            exp_sel = 5'd17;
            exp_link = d ? (bi ? pcv - 32'd8 : pcv - 32'd4) : (im ? pcv - 32'd4 : pcv);
            e_esr = 16'd16 | {14'h0, ms, a == 2'd2} | {5'h0, a == 2'd1, 10'h0} | {3'h0, d, 12'h0};
         end else begin
            exp_sel = (k == 2'd2) ? 5'd14 : 5'd16; exp_link = pcv;
         end
         if (k == 2'd0 || k == 2'd1) begin
            e_ear = pcv ^ 32'h00AB_C003;
            if (d) e_btr = pcv ^ 32'h5A5A_0000;
         end
         chk("R3 link we", {31'h0, lnk_we}, 32'h1);
         chk("R3 link sel", {27'h0, lnk_sel}, {27'h0, exp_sel});
         if (k == 2'd1) chk("R4 mmu return", lnk_val, exp_link);
         else chk("R3 link value", lnk_val, exp_link);
      end
      chk("R11 entered", {31'h0, entered}, {31'h0, acc_main});
      chk("R11 clears", {30'h0, resv_clr, iflag_clr}, {30'h0, acc_main, acc_main});
      chk("R2 pc", pc_q, e_pc);
      chk("R8 msr", msr_q, e_msr);
      if (k == 2'd1) chk("R6 esr", {16'h0, esr_q}, {16'h0, e_esr});
      else if (k == 2'd0) chk("R7 esr", {16'h0, esr_q}, {16'h0, e_esr});
      else chk("R11 esr kept", {16'h0, esr_q}, {16'h0, e_esr});
      chk("R6 ear", ear_q, e_ear);
      chk("R5 btr", btr_q, e_btr);
      chk("R12 no dfault", {31'h0, dfault}, 32'h0);
      chk("R10 noexc entered", {31'h0, n_entered}, {31'h0, acc_n});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      logic [31:0] pcv;
      pcv = 32'h0000_4000;
      repeat (2) @(posedge clk);
      @(negedge clk); rst = 0;
      check_reset_state();
      for (int k = 0; k < 4; k++)
         for (int mi = 0; mi < 32; mi++)
            for (int f = 0; f < 4; f++)
               for (int a = 0; a < 3; a++)
                  for (int ms = 0; ms < 2; ms++) begin
                     logic [31:0] m;
                     logic d, im, bi;
                     m = 32'h0000_0020 | (mi[0] ? 32'h2 : 0) | (mi[1] ? 32'h8 : 0) |
                         (mi[2] ? 32'h200 : 0) | (mi[3] ? 32'h800 : 0) | (mi[4] ? 32'h2000 : 0);
                     d  = (f >= 2);
                     im = (f == 1);
                     bi = (f == 3);
                     pcv = pcv + 32'd12;
                     run_trap(k[1:0], m, d, im, bi, a[1:0], ms[0], a[0] ^ ms[0],
                              7'(mi * 5 + f), pcv);
                  end
      // R12: second MMU fault while the first one is pending
      @(negedge clk);
      take = 1; kind = 2'd1; cur_msr = 32'h0; cur_pc = 32'h0000_9000; acc = 2'd0;
      in_dly = 0; after_imm = 0; fault_addr = 32'h1234_5678; miss = 1;
      @(posedge clk);
      @(negedge clk);
      chk("R12 first fault enters", {31'h0, entered}, 32'h1);
      e_pc = pc_q;
      kind = 2'd1; cur_msr = 32'h0000_0200; cur_pc = 32'h0000_9100;
      @(posedge clk);
      @(negedge clk);
      take = 0; cur_msr = 32'h0000_0200;
      chk("R12 dfault raised", {31'h0, dfault}, 32'h1);
      chk("R12 no entry", {31'h0, entered}, 32'h0);
      chk("R12 pc kept", pc_q, e_pc);
      repeat (3) @(negedge clk);
      cur_msr = 32'h0;
      repeat (2) @(negedge clk);
      chk("R12 dfault sticky", {31'h0, dfault}, 32'h1);
      // R1: reset clears everything again
      rst = 1;
      @(posedge clk);
      @(negedge clk);
      rst = 0;
      check_reset_state();
      finish_run();
   end
endmodule